// File: doc/BRIEF.md
# Multi-Width Saturating Adder with Sticky Overflow Status

This block adds or subtracts two data words. The word is treated as one full-width element, as two half-width lanes or as four byte lanes. Each lane is computed on its own. No carry or borrow passes from one lane to the next. When saturation is enabled, a lane whose true result falls outside the range of its element type is clamped to the nearest bound of that type, signed or unsigned. Without saturation the lane wraps.

For every operation the datapath produces an overflow indication taken from the true, unclamped results. A small status unit keeps two flags:

- A per-operation flag, rewritten by each accepted operation.
- A sticky flag, which collects overflows over a run of operations until an explicit clear command.

Two trap-request outputs test these flags when a trap command is presented. Software can always see the flags. A write port can load the flags only while the supervisor input is high.

Top module: `satadd_status`

## Requirements
- R1: With `op_sat`=1 and `op_unsigned`=0, a lane whose true result exceeds 2^(W-1)-1 gives 2^(W-1)-1, and one below -2^(W-1) gives -2^(W-1). Here W is the lane width: 32 for `op_width`=00 or 11, 16 for 01 and 8 for 10. Lane i occupies bits [i*W +: W].
- R2: With `op_sat`=1 and `op_unsigned`=1, an addition above 2^W-1 gives 2^W-1 in that lane, and a subtraction that borrows gives 0 in that lane.
- R3: With `op_sat`=0, each lane result is the true result modulo 2^W. No carry or borrow crosses a lane boundary.
- R4: `op_ovf` is the OR over all lanes of "true result outside the signed (or unsigned) W-bit range". It does not depend on `op_sat`.
- R5: On a clock edge with `op_valid`=1, `stat_v` takes the value of `op_ovf`. Without `op_valid`, a clear or an accepted write, `stat_v` holds.
- R6: `stat_sv` becomes 1 on any accepted operation with `op_ovf`=1. It stays 1 across later operations until cleared or overwritten.
- R7: `cmd_clr_ovf`=1 clears both `stat_v` and `stat_sv` at the next edge. It takes priority over a flag write and an operation in the same cycle.
- R8: `trap_v_req` = `cmd_trap_v` AND `stat_v`, and `trap_sv_req` = `cmd_trap_sv` AND `stat_sv`, both without a clock delay.
- R9: With `flag_wr_en`=1 and `supervisor`=1, the flags load `flag_wr_v` and `flag_wr_sv` at the next edge, taking priority over an operation. With `supervisor`=0 the write has no effect.
- R10: While `rst_n` is low, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation accepted this cycle; updates flags |
| op_sub | input | 1 | 1 = subtract b from a, 0 = add |
| op_unsigned | input | 1 | 1 = unsigned lanes, 0 = two's complement |
| op_sat | input | 1 | 1 = clamp out-of-range lanes |
| op_width | input | 2 | 00/11 full word, 01 half lanes, 10 byte lanes |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| result | output | DATA_W | Combinational result |
| op_ovf | output | 1 | Combinational overflow of this operation |
| cmd_clr_ovf | input | 1 | Clear both flags |
| cmd_trap_v | input | 1 | Trap-on-overflow command |
| cmd_trap_sv | input | 1 | Trap-on-sticky-overflow command |
| trap_v_req | output | 1 | Trap request from the per-operation flag |
| trap_sv_req | output | 1 | Trap request from the sticky flag |
| flag_wr_en | input | 1 | Flag write request |
| flag_wr_v | input | 1 | Value written to the per-operation flag |
| flag_wr_sv | input | 1 | Value written to the sticky flag |
| supervisor | input | 1 | Privilege level; enables flag writes |
| stat_v | output | 1 | Per-operation overflow flag |
| stat_sv | output | 1 | Sticky overflow flag |

## Verification
The bench drives operations that sit exactly one step past each signed and unsigned bound, in every lane width. This catches a clamp to the wrong bound or an off-by-one limit. It also drives packed operations in which one lane overflows while a neighbour does not, or wraps across the lane edge. A design that lets a carry leak between lanes, or clamps every lane together, corrupts the neighbour. Subtraction from zero of the most negative value, and unsigned borrow, are exercised, because a design that judges overflow from the clamped value instead of the true one misses them. The status sequence covers the following cases:

- a clean operation after an overflow, which must clear only the per-operation flag;
- an unprivileged write, which must change nothing;
- a clear that coincides with both an overflowing operation and a privileged write.

// File: rtl/satadd_pkg.sv
package satadd_pkg;
   typedef enum logic [1:0] {
      WSEL_FULL = 2'b00,
      WSEL_HALF = 2'b01,
      WSEL_BYTE = 2'b10,
      WSEL_ALT  = 2'b11
   } wsel_e;
endpackage

// File: rtl/satadd_lane.sv
module satadd_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         uns,
   input  logic         sat,
   output logic [W-1:0] res,
   output logic         ovf
);
   localparam int EW = W + 2;

   if (W < 2) begin : g_bad_w
      $error("satadd_lane: W must be at least 2");
   end

   logic [EW-1:0] ea, eb, tru;
   logic [W-1:0]  clampv;

   always_comb begin
      ea  = uns ? {2'b00, a} : {{2{a[W-1]}}, a};
      eb  = uns ? {2'b00, b} : {{2{b[W-1]}}, b};
      tru = sub ? (ea - eb) : (ea + eb);
      // true result is judged before any clamping
      if (uns) ovf = tru[W+1] | tru[W];
      else     ovf = tru[W] ^ tru[W-1];
      if (uns) clampv = tru[W+1] ? '0 : '1;
      else     clampv = tru[W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      res = (sat && ovf) ? clampv : tru[W-1:0];
   end
endmodule

// File: rtl/satadd_bank.sv
module satadd_bank #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              uns,
   input  logic              sat,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);
   localparam int NLANE = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_div
      $error("satadd_bank: DATA_W must be a multiple of LANE_W");
   end

   logic [NLANE-1:0] lane_ovf;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      satadd_lane #(.W(LANE_W)) u_lane (
         .a   (a[i*LANE_W +: LANE_W]),
         .b   (b[i*LANE_W +: LANE_W]),
         .sub (sub),
         .uns (uns),
         .sat (sat),
         .res (res[i*LANE_W +: LANE_W]),
         .ovf (lane_ovf[i])
      );
   end

   assign ovf = |lane_ovf;
endmodule

// File: rtl/satadd_flags.sv
module satadd_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  logic op_ovf,
   input  logic cmd_clr,
   input  logic wr_en,
   input  logic wr_v,
   input  logic wr_sv,
   input  logic supervisor,
   output logic v,
   output logic sv
);
   logic wr_ok;
   assign wr_ok = wr_en & supervisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v  <= 1'b0;
         sv <= 1'b0;
      end else if (cmd_clr) begin
         v  <= 1'b0;
         sv <= 1'b0;
      end else if (wr_ok) begin
         v  <= wr_v;
         sv <= wr_sv;
      end else if (op_valid) begin
         v  <= op_ovf;
         sv <= sv | op_ovf;
      end
   end

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clr |=> (!v && !sv)); // R7
   AST_V_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !cmd_clr && !(wr_en && supervisor)) |=> (v == $past(op_ovf))); // R5
   AST_SV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sv && !cmd_clr && !(wr_en && supervisor)) |=> sv); // R6
   AST_SV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ovf && !cmd_clr && !(wr_en && supervisor)) |=> sv); // R6
   AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !supervisor && !cmd_clr && !op_valid) |=> ($stable(v) && $stable(sv))); // R9
endmodule

// File: rtl/satadd_status.sv
module satadd_status #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_sub,
   input  logic              op_unsigned,
   input  logic              op_sat,
   input  logic [1:0]        op_width,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result,
   output logic              op_ovf,
   input  logic              cmd_clr_ovf,
   input  logic              cmd_trap_v,
   input  logic              cmd_trap_sv,
   output logic              trap_v_req,
   output logic              trap_sv_req,
   input  logic              flag_wr_en,
   input  logic              flag_wr_v,
   input  logic              flag_wr_sv,
   input  logic              supervisor,
   output logic              stat_v,
   output logic              stat_sv
);
   import satadd_pkg::*;

   localparam int HALF_W = DATA_W / 2;
   localparam int BYTE_W = DATA_W / 4;

   if (DATA_W < 16 || DATA_W % 16 != 0) begin : g_bad_data_w
      $error("satadd_status: DATA_W must be a multiple of 16");
   end

   logic [DATA_W-1:0] res_full, res_half, res_byte;
   logic              ovf_full, ovf_half, ovf_byte;

   satadd_bank #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_full (
      .a(opa), .b(opb), .sub(op_sub), .uns(op_unsigned), .sat(op_sat),
      .res(res_full), .ovf(ovf_full));
   satadd_bank #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_half (
      .a(opa), .b(opb), .sub(op_sub), .uns(op_unsigned), .sat(op_sat),
      .res(res_half), .ovf(ovf_half));
   satadd_bank #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_byte (
      .a(opa), .b(opb), .sub(op_sub), .uns(op_unsigned), .sat(op_sat),
      .res(res_byte), .ovf(ovf_byte));

   always_comb begin
      unique case (wsel_e'(op_width))
         WSEL_HALF: begin result = res_half; op_ovf = ovf_half; end
         WSEL_BYTE: begin result = res_byte; op_ovf = ovf_byte; end
         default:   begin result = res_full; op_ovf = ovf_full; end
      endcase
   end

   satadd_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_ovf     (op_ovf),
      .cmd_clr    (cmd_clr_ovf),
      .wr_en      (flag_wr_en),
      .wr_v       (flag_wr_v),
      .wr_sv      (flag_wr_sv),
      .supervisor (supervisor),
      .v          (stat_v),
      .sv         (stat_sv)
   );

   assign trap_v_req  = cmd_trap_v  & stat_v;
   assign trap_sv_req = cmd_trap_sv & stat_sv;

   AST_TRAP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_trap_v && !cmd_trap_sv) |-> (!trap_v_req && !trap_sv_req)); // R8
endmodule

// File: tb/tb_satadd_status.sv
module tb_satadd_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_sub = 1'b0, op_unsigned = 1'b0, op_sat = 1'b0;
   logic [1:0]  op_width = 2'b00;
   logic [31:0] opa = '0, opb = '0;
   logic [31:0] result;
   logic        op_ovf;
   logic        cmd_clr_ovf = 1'b0, cmd_trap_v = 1'b0, cmd_trap_sv = 1'b0;
   logic        trap_v_req, trap_sv_req;
   logic        flag_wr_en = 1'b0, flag_wr_v = 1'b0, flag_wr_sv = 1'b0, supervisor = 1'b0;
   logic        stat_v, stat_sv;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   satadd_status #(.DATA_W(32)) dut (.*);

   typedef struct packed {
      logic        sub;
      logic        uns;
      logic        sat;
      logic [1:0]  w;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] res;
      logic        ovf;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b1,2'b00,32'h7FFFFFFF,32'h00000001,32'h7FFFFFFF,1'b1}, // R1 max
      '{1'b1,1'b0,1'b1,2'b00,32'h80000000,32'h00000001,32'h80000000,1'b1}, // R1 min
      '{1'b0,1'b0,1'b0,2'b00,32'h7FFFFFFF,32'h00000001,32'h80000000,1'b1}, // R3 R4 wrap
      '{1'b0,1'b0,1'b1,2'b00,32'h00000005,32'hFFFFFFFD,32'h00000002,1'b0}, // R4 clean
      '{1'b0,1'b1,1'b1,2'b00,32'hFFFFFFF0,32'h00000020,32'hFFFFFFFF,1'b1}, // R2
      '{1'b1,1'b1,1'b1,2'b00,32'h00000005,32'h00000006,32'h00000000,1'b1}, // R2 borrow
      '{1'b1,1'b1,1'b0,2'b00,32'h00000005,32'h00000006,32'hFFFFFFFF,1'b1}, // R3
      '{1'b0,1'b0,1'b1,2'b01,32'h7FFF0001,32'h00010002,32'h7FFF0003,1'b1}, // R1 half
      '{1'b1,1'b0,1'b1,2'b01,32'h80000010,32'h00010020,32'h8000FFF0,1'b1}, // R1 half
      '{1'b0,1'b0,1'b1,2'b01,32'h12340001,32'h0001FFFF,32'h12350000,1'b0}, // R3 no leak
      '{1'b0,1'b1,1'b1,2'b01,32'hFFFF0001,32'h00010001,32'hFFFF0002,1'b1}, // R2 half
      '{1'b0,1'b0,1'b1,2'b10,32'h7F800102,32'h01010304,32'h7F810406,1'b1}, // R1 byte
      '{1'b1,1'b0,1'b1,2'b10,32'h807F0010,32'h01FF0110,32'h807FFF00,1'b1}, // R1 byte
      '{1'b1,1'b1,1'b1,2'b10,32'h05FF1000,32'h06011001,32'h00FE0000,1'b1}, // R2 byte
      '{1'b0,1'b1,1'b1,2'b10,32'hF0108001,32'h20108001,32'hFF20FF02,1'b1}, // R2 byte
      '{1'b0,1'b1,1'b0,2'b10,32'hFF010000,32'h01010000,32'h00020000,1'b1}, // R3 byte
      '{1'b0,1'b0,1'b1,2'b10,32'h10203040,32'h01020304,32'h11223344,1'b0}, // R4 clean
      '{1'b1,1'b0,1'b1,2'b11,32'h00000000,32'h80000000,32'h7FFFFFFF,1'b1}  // R1 R4
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic sv_exp;
      sv_exp = 1'b0;
      cmd_trap_v = 1'b1; cmd_trap_sv = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R10 reset v", {31'b0, stat_v}, 32'd0);
      chk("R10 reset sv", {31'b0, stat_sv}, 32'd0);
      chk("R8 reset traps", {30'b0, trap_v_req, trap_sv_req}, 32'd0);
      cmd_trap_v = 1'b0; cmd_trap_sv = 1'b0;
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_valid = 1'b1; op_sub = VEC[i].sub; op_unsigned = VEC[i].uns;
         op_sat = VEC[i].sat; op_width = VEC[i].w; opa = VEC[i].a; opb = VEC[i].b;
         #1;
         chk($sformatf("R1/R2/R3 result vec %0d", i), result, VEC[i].res);
         chk($sformatf("R4 ovf vec %0d", i), {31'b0, op_ovf}, {31'b0, VEC[i].ovf});
         sv_exp = sv_exp | VEC[i].ovf;
         @(posedge clk); #1;
         chk($sformatf("R5 v vec %0d", i), {31'b0, stat_v}, {31'b0, VEC[i].ovf});
         chk($sformatf("R6 sv vec %0d", i), {31'b0, stat_sv}, {31'b0, sv_exp});
      end

      // idle cycle: flags hold
      @(negedge clk); op_valid = 1'b0;
      @(posedge clk); #1;
      chk("R5 hold v", {31'b0, stat_v}, 32'd1);
      // traps with both flags set
      @(negedge clk); cmd_trap_v = 1'b1; cmd_trap_sv = 1'b1; #1;
      chk("R8 trap_v set", {31'b0, trap_v_req}, 32'd1);
      chk("R8 trap_sv set", {31'b0, trap_sv_req}, 32'd1);
      // clean operation: v drops, sv stays
      op_valid = 1'b1; op_sub = 1'b0; op_unsigned = 1'b0; op_sat = 1'b1;
      op_width = 2'b00; opa = 32'd5; opb = 32'hFFFFFFFD;
      @(posedge clk); #1;
      chk("R6 sv sticky", {31'b0, stat_sv}, 32'd1);
      chk("R5 v cleared by clean op", {31'b0, stat_v}, 32'd0);
      chk("R8 trap_v off", {31'b0, trap_v_req}, 32'd0);
      chk("R8 trap_sv on", {31'b0, trap_sv_req}, 32'd1);
      @(negedge clk); op_valid = 1'b0; cmd_trap_v = 1'b0; cmd_trap_sv = 1'b0;
      // unprivileged write ignored
      flag_wr_en = 1'b1; flag_wr_v = 1'b1; flag_wr_sv = 1'b0; supervisor = 1'b0;
      @(posedge clk); #1;
      chk("R9 user write v", {31'b0, stat_v}, 32'd0);
      chk("R9 user write sv", {31'b0, stat_sv}, 32'd1);
      // privileged write, also beats an overflowing operation
      @(negedge clk); supervisor = 1'b1;
      op_valid = 1'b1; opa = 32'h7FFFFFFF; opb = 32'd1;
      @(posedge clk); #1;
      chk("R9 sup write v", {31'b0, stat_v}, 32'd1);
      chk("R9 sup write sv", {31'b0, stat_sv}, 32'd0);
      @(negedge clk); flag_wr_en = 1'b0; supervisor = 1'b0; op_valid = 1'b0;
      cmd_clr_ovf = 1'b1;
      @(posedge clk); #1;
      chk("R7 clear", {30'b0, stat_v, stat_sv}, 32'd0);
      // clear with overflowing op and privileged write in same cycle
      @(negedge clk); op_valid = 1'b1; flag_wr_en = 1'b1; supervisor = 1'b1;
      flag_wr_v = 1'b1; flag_wr_sv = 1'b1;
      @(posedge clk); #1;
      chk("R7 clear priority", {30'b0, stat_v, stat_sv}, 32'd0);
      @(negedge clk); cmd_clr_ovf = 1'b0; flag_wr_en = 1'b0; supervisor = 1'b0;
      @(posedge clk); #1;
      chk("R6 set after clear", {30'b0, stat_v, stat_sv}, 32'd3);
      @(negedge clk); op_valid = 1'b0; rst_n = 1'b0; #1;
      chk("R10 async reset", {30'b0, stat_v, stat_sv}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule